// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two operands, a five-bit condition mask and a width select. It compares the operands both as signed and as unsigned numbers. Each of the five possible outcomes is gated by its own mask bit. If any gated outcome holds, the block asks for a program exception of the trap kind.

The comparison logic is purely combinational. The verdict is captured in a register, so it appears on the response outputs one clock after the request is presented. In word mode only the low half of each operand takes part. Signed tests then treat bit 31 as the sign. The upper half has no influence in this mode.

Top module: `trapCmpTop`

## Requirements
- R1: While reset is asserted, and after its release until the first request, `rspValid`, `rspTrap` and `rspCode` are all zero.
- R2: Mask bit 4 (value 0x10) causes a trap when operand A is less than operand B, both read as two's-complement numbers.
- R3: Mask bit 3 (value 0x08) causes a trap when A is greater than B, both read as two's-complement numbers.
- R4: Mask bit 2 (value 0x04) causes a trap when A equals B.
- R5: Mask bit 1 (value 0x02) causes a trap when A is less than B, both read as unsigned numbers.
- R6: Mask bit 0 (value 0x01) causes a trap when A is greater than B, both read as unsigned numbers.
- R7: The trap fires when at least one enabled test holds. A mask of 0x00 never traps. A mask of 0x1F always traps.
- R8: When `wideMode` is 0, only bits 31:0 of each operand are compared, with bit 31 as the sign, and bits 63:32 have no effect. When `wideMode` is 1, all 64 bits are compared.
- R9: A request sampled at a rising edge produces `rspValid`=1 after that edge. On a trap `rspCode` then equals the trap code parameter (default 0x24), and otherwise it is 0. A cycle with no request yields `rspValid`=0 and `rspTrap`=0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A compare request is present this cycle |
| wideMode | input | 1 | 1 selects a 64-bit compare, 0 selects a 32-bit compare |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| condMask | input | 5 | Condition mask; the bit meanings are given in R2 to R6 |
| rspValid | output | 1 | The response fields hold a verdict |
| rspTrap | output | 1 | A trap is requested |
| rspCode | output | 8 | The trap error code when a trap is requested, otherwise 0 |

## Verification
The assertions assume that the operands, mask and mode are stable for the whole cycle in which `reqValid` is high. They also assume that they are never unknown when sampled. The bench changes inputs only on falling clock edges and always drives every field of a request. The assertions therefore see a settled request at each rising edge and compare it with the registered verdict one cycle later.

// File: rtl/trapCmpPkg.sv
package trapCmpPkg;
  // One flag per comparison; the bit order matches the condition mask.
  typedef struct packed {
    logic ltSigned;    // mask bit 4
    logic gtSigned;    // mask bit 3
    logic equal;       // mask bit 2
    logic ltUnsigned;  // mask bit 1
    logic gtUnsigned;  // mask bit 0
  } cmpFlags_t;

  localparam int COND_W = $bits(cmpFlags_t);

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture a fresh verdict
    logic clear;  // drop the held verdict
  } ctrlStrobes_t;
endpackage

// File: rtl/trapCmpDatapath.sv
module trapCmpDatapath
  import trapCmpPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] TRAP_CODE = 8'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [COND_W-1:0] condMask,
  output logic              rspTrap,
  output logic [CODE_W-1:0] rspCode
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] rawOp  [2];
  logic [DATA_W-1:0] unsOp  [2];
  logic [DATA_W-1:0] sgnOp  [2];
  cmpFlags_t         flags;
  logic              hitAny;

  assign rawOp[0] = opA;
  assign rawOp[1] = opB;

  // Width select per operand: zero extension for unsigned, sign extension for signed.
  for (genvar k = 0; k < 2; k++) begin : g_opSel
    always_comb begin
      if (wideMode) begin
        unsOp[k] = rawOp[k];
        sgnOp[k] = rawOp[k];
      end else begin
        unsOp[k] = {{HALF_W{1'b0}}, rawOp[k][HALF_W-1:0]};
        sgnOp[k] = {{HALF_W{rawOp[k][HALF_W-1]}}, rawOp[k][HALF_W-1:0]};
      end
    end
  end

  always_comb begin
    flags.ltSigned   = $signed(sgnOp[0]) < $signed(sgnOp[1]);
    flags.gtSigned   = $signed(sgnOp[0]) > $signed(sgnOp[1]);
    flags.equal      = unsOp[0] == unsOp[1];
    flags.ltUnsigned = unsOp[0] < unsOp[1];
    flags.gtUnsigned = unsOp[0] > unsOp[1];
  end

  assign hitAny = |(flags & condMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspTrap <= 1'b0;
      rspCode <= '0;
    end else if (strobes.load) begin
      rspTrap <= hitAny;
      rspCode <= hitAny ? TRAP_CODE : '0;
    end else if (strobes.clear) begin
      rspTrap <= 1'b0;
      rspCode <= '0;
    end
  end

  // R2 R3 R4: the signed ordering outcomes are mutually exclusive.
  p_sgn_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(flags[4:2]));
  // R5 R6: the unsigned ordering outcomes are mutually exclusive.
  p_uns_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({flags.ltUnsigned, flags.gtUnsigned, flags.equal}));
endmodule

// File: rtl/trapCmpCtrl.sv
module trapCmpCtrl
  import trapCmpPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output ctrlStrobes_t strobes,
  output logic         rspValid
);
  always_comb begin
    strobes.load  = reqValid;
    strobes.clear = !reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/trapCmpTop.sv
module trapCmpTop
  import trapCmpPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] TRAP_CODE = 8'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [4:0]        condMask,
  output logic              rspValid,
  output logic              rspTrap,
  output logic [CODE_W-1:0] rspCode
);
  localparam int HALF_W = DATA_W / 2;
  ctrlStrobes_t strobes;

  trapCmpCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .strobes(strobes), .rspValid(rspValid)
  );

  trapCmpDatapath #(.DATA_W(DATA_W), .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wideMode(wideMode),
    .opA(opA), .opB(opB), .condMask(condMask),
    .rspTrap(rspTrap), .rspCode(rspCode)
  );

  p_valid_follows_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_no_trap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspTrap && rspCode == '0));
  p_trap_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspTrap |-> (rspValid && rspCode == TRAP_CODE));
  p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && condMask == 5'h00) |=> !rspTrap);
  p_full_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && condMask == 5'h1F) |=> rspTrap);
  p_equal_traps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && condMask[2] &&
     (wideMode ? (opA == opB) : (opA[HALF_W-1:0] == opB[HALF_W-1:0]))) |=> rspTrap);
endmodule

// File: tb/trapCmpTop_tb_top.sv
`timescale 1ns/1ps
module trapCmpTop_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        wideMode = 1'b1;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [4:0]  condMask = '0;
  logic        rspValid, rspTrap;
  logic [7:0]  rspCode;

  int checks = 0;
  int errors = 0;
  localparam logic [7:0] CODE = 8'h24;

  always #2.5 clk = ~clk;

  trapCmpTop dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wideMode(wideMode),
    .opA(opA), .opB(opB), .condMask(condMask),
    .rspValid(rspValid), .rspTrap(rspTrap), .rspCode(rspCode)
  );

  // Vector: {wide, A, B, mask, expected trap}
  localparam int NV = 16;
  localparam logic [134:0] VEC [NV] = '{
    {1'b1, 64'd5, 64'd7, 5'h10, 1'b1},                                     // R2 5<7
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h02, 1'b0},                   // R5 max not < 1
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, 1'b1},                   // R2 -1<1
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, 1'b1},                   // R6 max>1
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h08, 1'b0},                   // R3 -1 not > 1
    {1'b1, 64'h1234, 64'h1234, 5'h04, 1'b1},                               // R4 equal
    {1'b1, 64'h1234, 64'h1234, 5'h1B, 1'b0},                               // R7 equal, eq off
    {1'b1, 64'd3, 64'd9, 5'h00, 1'b0},                                     // R7 zero mask
    {1'b1, 64'd0, 64'd0, 5'h1F, 1'b1},                                     // R7 full mask, equal
    {1'b1, 64'd9, 64'd3, 5'h1F, 1'b1},                                     // R7 full mask, greater
    {1'b0, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 5'h04, 1'b1}, // R8 low equal
    {1'b1, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 5'h04, 1'b0}, // R8 wide differs
    {1'b0, 64'h0000_0000_8000_0000, 64'd1, 5'h10, 1'b1},                   // R8 word sign bit 31
    {1'b1, 64'h0000_0000_8000_0000, 64'd1, 5'h10, 1'b0},                   // R2 wide positive
    {1'b0, 64'hFFFF_FFFF_0000_0001, 64'd2, 5'h01, 1'b0},                   // R8 upper ignored
    {1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 5'h09, 1'b1}  // R3 off, R6 on
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runReq(input string req, input logic w, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] m, input logic expT);
    reqValid = 1'b1; wideMode = w; opA = a; opB = b; condMask = m;
    @(negedge clk);
    check({req, " R9 valid"}, {31'd0, rspValid}, 32'd1);
    check({req, " trap"}, {31'd0, rspTrap}, {31'd0, expT});
    check({req, " R9 code"}, {24'd0, rspCode}, expT ? {24'd0, CODE} : 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 valid in reset", {31'd0, rspValid}, 32'd0);
    check("R1 trap in reset", {31'd0, rspTrap}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, rspValid}, 32'd0);
    check("R1 code after reset", {24'd0, rspCode}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      runReq($sformatf("vector %0d", i), VEC[i][134], VEC[i][133:70],
             VEC[i][69:6], VEC[i][5:1], VEC[i][0]);
    end

    // R9: an idle cycle clears a held trap.
    runReq("R9 prime", 1'b1, 64'd1, 64'd2, 5'h10, 1'b1);
    reqValid = 1'b0; condMask = 5'h1F;
    @(negedge clk);
    check("R9 idle valid", {31'd0, rspValid}, 32'd0);
    check("R9 idle trap", {31'd0, rspTrap}, 32'd0);

    // R8: only the upper halves differ; the word compare sees equality.
    runReq("R8 upper only", 1'b0, 64'h0123_4567_0000_0010, 64'hFEDC_BA98_0000_0010, 5'h1B, 1'b0);
    runReq("R4 R8 word eq", 1'b0, 64'h0123_4567_0000_0010, 64'hFEDC_BA98_0000_0010, 5'h04, 1'b1);
    // R5: unsigned less in word mode on low halves.
    runReq("R5 word", 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_FFFF_FFFF, 5'h02, 1'b1);

    // R1: reset asserted mid-stream clears the outputs.
    runReq("R1 prime", 1'b1, 64'd4, 64'd4, 5'h04, 1'b1);
    rstN = 1'b0;
    #1;
    check("R1 reset valid", {31'd0, rspValid}, 32'd0);
    check("R1 reset trap", {31'd0, rspTrap}, 32'd0);
    reqValid = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 post reset", {31'd0, rspValid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule